// File: doc/BRIEF.md
# Flash Erase-Verify Section Sequencer

This block runs one command: it confirms that a contiguous run of 64-bit flash phrases reads back fully erased. Software loads three indexed 16-bit parameter words while the block is idle, then raises the launch strobe. Raising launch stands for clearing the command-complete flag. The block first vets the parameters. Any fault sets the access-error flag and ends the command without touching memory. If the parameters are sound, the block walks the range one phrase at a time through a simple read port. That port returns the data together with two error-correction status bits.

Parameter word 0 carries the command code in bits [15:8] and global address bits [22:16] in bits [6:0]. Word 1 carries address bits [15:0] of the first phrase. Word 2 carries the phrase count. When the walk ends, the complete flag rises. Two result flags then report what was seen: the any-error flag and the uncorrectable-error flag.

Top module: `fev_seq`

## Requirements
- R1: After reset, `done` is 1, `acc_err`, `rd_err` and `rd_unc` are 0, and `mem_req` is 0.
- R2: A parameter write (`prm_wr`, index `prm_idx` 0, 1 or 2 selecting word 0, 1 or 2) is stored only while `done` is 1. The index of the last accepted write is remembered. Writes while `done` is 0 change neither the words nor the remembered index.
- R3: A launch sampled while `done` is 1 drops `done` on that edge and clears all three status flags. A launch while `done` is 0 is ignored.
- R4: `acc_err` is set if the last accepted write index was not 2, or if word 0 bits [15:8] differ from 0x03.
- R5: `acc_err` is set if the start address {word0[6:0], word1} has bits [2:0] not equal to 000.
- R6: `acc_err` is set if the start address lies outside the parameter range, which by default is 0x7E0000 to 0x7FFFFF.
- R7: `acc_err` is set if the phrase count is 0, or if start[16:0] plus 8 times the count exceeds 0x20000. Reaching exactly 0x20000 is allowed.
- R8: On an access error, no read is issued. `acc_err` and `done` both rise on the edge after the launch edge.
- R9: For a valid command, the block issues exactly count reads, one at a time, at addresses start, start+8, start+16 and so on. It waits for `mem_vld` (one cycle after `mem_req`) before each next read. `done` rises on the edge that takes the last `mem_vld`.
- R10: `rd_err` is set if any phrase read has a 0 data bit, or comes back with `mem_cor` or `mem_unc` high.
- R11: `rd_unc` is set if any phrase read comes back with `mem_unc` high. `rd_unc` implies `rd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prm_wr | input | 1 | Parameter word write strobe |
| prm_idx | input | 3 | Parameter word index |
| prm_data | input | 16 | Parameter word value |
| launch | input | 1 | Start command (clears complete flag) |
| done | output | 1 | Command complete flag |
| acc_err | output | 1 | Access error flag |
| rd_err | output | 1 | Any read error or non-erased phrase |
| rd_unc | output | 1 | Uncorrectable read error seen |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | 23 | Phrase address of the read |
| mem_vld | input | 1 | Read data valid, one cycle after request |
| mem_data | input | 64 | Phrase data |
| mem_cor | input | 1 | Correctable error on this read |
| mem_unc | input | 1 | Uncorrectable error on this read |

## Verification
A faulty parameter check shows up at the ports two edges after launch. Either `acc_err` rises with no reads, or reads begin where none should. A wrong address counter or remaining-count register shows up as a wrong `mem_addr` on some request, or a read total that differs from the phrase count, once `done` rises. Errors in the status accumulation are visible only at completion. They appear as result flags that disagree with the injected fault kind. Flags left over from the previous command would show at the following launch.

// File: rtl/fev_seq.sv
module fev_seq #(
  parameter int          CNT_W    = 16,
  parameter int          PHR_W    = 64,
  parameter logic [7:0]  CMD_CODE = 8'h03,
  parameter logic [22:0] ADDR_LO  = 23'h7E0000,
  parameter logic [22:0] ADDR_HI  = 23'h7FFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prm_wr,
  input  logic [2:0]       prm_idx,
  input  logic [15:0]      prm_data,
  input  logic             launch,
  output logic             done,
  output logic             acc_err,
  output logic             rd_err,
  output logic             rd_unc,
  output logic             mem_req,
  output logic [22:0]      mem_addr,
  input  logic             mem_vld,
  input  logic [PHR_W-1:0] mem_data,
  input  logic             mem_cor,
  input  logic             mem_unc
);

  localparam int SEG_W = 17;
  localparam int SUM_W = (SEG_W > CNT_W + 3 ? SEG_W : CNT_W + 3) + 1;
  localparam logic [SUM_W-1:0] SEG_SIZE = SUM_W'(1) << SEG_W;

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_RD, S_WT} st_t;

  st_t              st;
  logic [15:0]      w0, w1;
  logic [CNT_W-1:0] w2, left;
  logic [2:0]       last_idx;
  logic [22:0]      cur;

  wire [22:0]      start   = {w0[6:0], w1};
  wire [SUM_W-1:0] seg_end = SUM_W'(start[SEG_W-1:0]) + (SUM_W'(w2) << 3);

  wire bad_cmd   = (last_idx != 3'd2) || (w0[15:8] != CMD_CODE);
  wire bad_align = start[2:0] != 3'b000;
  wire bad_range = (start < ADDR_LO) || (start > ADDR_HI);
  wire bad_len   = (w2 == '0) || (seg_end > SEG_SIZE);
  wire bad       = bad_cmd || bad_align || bad_range || bad_len;

  wire phr_bad = (mem_data != {PHR_W{1'b1}}) || mem_cor || mem_unc;

  assign mem_req  = st == S_RD;
  assign mem_addr = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      done     <= 1'b1;
      acc_err  <= 1'b0;
      rd_err   <= 1'b0;
      rd_unc   <= 1'b0;
      w0       <= '0;
      w1       <= '0;
      w2       <= '0;
      last_idx <= '0;
      cur      <= '0;
      left     <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (prm_wr) begin
            last_idx <= prm_idx;
            case (prm_idx)
              3'd0:    w0 <= prm_data;
              3'd1:    w1 <= prm_data;
              3'd2:    w2 <= CNT_W'(prm_data);
              default: ;
            endcase
          end
          if (launch) begin
            done    <= 1'b0;
            acc_err <= 1'b0;
            rd_err  <= 1'b0;
            rd_unc  <= 1'b0;
            st      <= S_CHK;
          end
        end
        S_CHK: begin
          if (bad) begin
            acc_err <= 1'b1;
            done    <= 1'b1;
            st      <= S_IDLE;
          end else begin
            cur  <= start;
            left <= w2;
            st   <= S_RD;
          end
        end
        S_RD: st <= S_WT;
        S_WT: begin
          if (mem_vld) begin
            rd_err <= rd_err | phr_bad;
            rd_unc <= rd_unc | mem_unc;
            if (left == CNT_W'(1)) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              left <= left - CNT_W'(1);
              cur  <= cur + 23'd8;
              st   <= S_RD;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fev_seq_chk.sv
module fev_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        acc_err,
  input logic        rd_err,
  input logic        rd_unc,
  input logic        mem_req,
  input logic [22:0] mem_addr
);

  p_clear_on_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> (!acc_err && !rd_err && !rd_unc));

  p_align_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  p_accerr_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_err) |-> done);

  p_accerr_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !mem_req);

  p_idle_noreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  p_single_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_unc_implies_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unc |-> rd_err);

endmodule

bind fev_seq fev_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .acc_err(acc_err),
  .rd_err(rd_err), .rd_unc(rd_unc), .mem_req(mem_req), .mem_addr(mem_addr)
);

// File: tb/sim_fev_seq.sv
module sim_fev_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prm_wr = 1'b0;
  logic [2:0]  prm_idx = '0;
  logic [15:0] prm_data = '0;
  logic        launch = 1'b0;
  logic        done, acc_err, rd_err, rd_unc, mem_req;
  logic [22:0] mem_addr;
  logic        mem_vld = 1'b0;
  logic [63:0] mem_data = '1;
  logic        mem_cor = 1'b0;
  logic        mem_unc = 1'b0;

  always #2 clk = ~clk;

  fev_seq u0 (
    .clk(clk), .rst_n(rst_n), .prm_wr(prm_wr), .prm_idx(prm_idx),
    .prm_data(prm_data), .launch(launch), .done(done), .acc_err(acc_err),
    .rd_err(rd_err), .rd_unc(rd_unc), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_vld(mem_vld), .mem_data(mem_data), .mem_cor(mem_cor), .mem_unc(mem_unc)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  int          cyc = 0;
  int          n_rd = 0;
  logic [22:0] first_a = '0;
  logic [22:0] last_a = '0;
  logic        seq_bad = 1'b0;
  logic [15:0] f_lo = '0;
  logic [1:0]  f_kind = '0;

  always @(posedge clk) begin
    mem_vld <= mem_req;
    mem_data <= '1;
    mem_cor <= 1'b0;
    mem_unc <= 1'b0;
    if (mem_req) begin
      if (n_rd == 0) first_a <= mem_addr;
      else if (mem_addr != last_a + 23'd8) seq_bad <= 1'b1;
      last_a <= mem_addr;
      n_rd <= n_rd + 1;
      if (f_kind != 2'd0 && mem_addr[15:0] == f_lo) begin
        if (f_kind == 2'd1) mem_data <= ~(64'd1 << 37);
        if (f_kind == 2'd2) mem_cor <= 1'b1;
        if (f_kind == 2'd3) mem_unc <= 1'b1;
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] i, logic [15:0] d);
    @(negedge clk);
    prm_wr = 1'b1; prm_idx = i; prm_data = d;
    @(negedge clk);
    prm_wr = 1'b0;
  endtask

  task automatic go_wait();
    n_rd = 0; seq_bad = 1'b0;
    @(negedge clk);
    launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
    chk("R3 done low after launch", 32'(done), 0);
    chk("R3 flags cleared", {29'd0, acc_err, rd_err, rd_unc}, 0);
    for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
  endtask

  typedef struct packed {
    logic [15:0] w0, w1, cnt;
    logic        idx_ok;
    logic [15:0] flo;
    logic [1:0]  kind;
    logic        e_acc, e_err, e_unc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{16'h037E, 16'h0000, 16'd4,  1'b1, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0},
    '{16'h037E, 16'h0000, 16'd4,  1'b1, 16'h0010, 2'd1, 1'b0, 1'b1, 1'b0},
    '{16'h037E, 16'h0008, 16'd3,  1'b1, 16'h0018, 2'd2, 1'b0, 1'b1, 1'b0},
    '{16'h037E, 16'h0000, 16'd4,  1'b1, 16'h0018, 2'd3, 1'b0, 1'b1, 1'b1},
    '{16'h037E, 16'h0004, 16'd4,  1'b1, 16'h0000, 2'd0, 1'b1, 1'b0, 1'b0},
    '{16'h037F, 16'hFFF8, 16'd2,  1'b1, 16'h0000, 2'd0, 1'b1, 1'b0, 1'b0},
    '{16'h037F, 16'hFFF8, 16'd1,  1'b1, 16'hFFF8, 2'd3, 1'b0, 1'b1, 1'b1},
    '{16'h037D, 16'h0000, 16'd1,  1'b1, 16'h0000, 2'd0, 1'b1, 1'b0, 1'b0},
    '{16'h037E, 16'h0000, 16'd0,  1'b1, 16'h0000, 2'd0, 1'b1, 1'b0, 1'b0},
    '{16'h047E, 16'h0000, 16'd1,  1'b1, 16'h0000, 2'd0, 1'b1, 1'b0, 1'b0},
    '{16'h037E, 16'h0000, 16'd1,  1'b0, 16'h0000, 2'd0, 1'b1, 1'b0, 1'b0},
    '{16'h037F, 16'h0000, 16'd16, 1'b1, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", 32'(done), 1);
    chk("R1 flags", {29'd0, acc_err, rd_err, rd_unc}, 0);
    chk("R1 mem_req", 32'(mem_req), 0);

    for (int v = 0; v < NV; v++) begin
      logic [22:0] st_a;
      int          e_rd;
      st_a = {TBL[v].w0[6:0], TBL[v].w1};
      e_rd = TBL[v].e_acc ? 0 : int'(TBL[v].cnt);
      f_lo = TBL[v].flo; f_kind = TBL[v].kind;
      wr(3'd0, TBL[v].w0);
      wr(3'd1, TBL[v].w1);
      wr(3'd2, TBL[v].cnt);
      if (!TBL[v].idx_ok) wr(3'd1, TBL[v].w1);
      if (TBL[v].e_acc) begin
        // R8 access error ends on the edge after launch
        n_rd = 0;
        @(negedge clk); launch = 1'b1;
        @(negedge clk); launch = 1'b0;
        chk("R8 done low one cycle", 32'(done), 0);
        @(negedge clk);
        chk("R8 done back", 32'(done), 1);
      end else begin
        go_wait();
      end
      // R4 R5 R6 R7 parameter checks, R10 R11 result flags
      chk($sformatf("R4-7 acc_err vec%0d", v), 32'(acc_err), 32'(TBL[v].e_acc));
      chk($sformatf("R10 rd_err vec%0d", v), 32'(rd_err), 32'(TBL[v].e_err));
      chk($sformatf("R11 rd_unc vec%0d", v), 32'(rd_unc), 32'(TBL[v].e_unc));
      chk($sformatf("R9 reads vec%0d", v), 32'(n_rd), 32'(e_rd));
      if (e_rd > 0) begin
        chk($sformatf("R9 first addr vec%0d", v), 32'(first_a), 32'(st_a));
        chk($sformatf("R9 addr step vec%0d", v), 32'(seq_bad), 0);
      end
    end

    // R2 writes while busy are ignored
    f_kind = 2'd0;
    wr(3'd0, 16'h037E); wr(3'd1, 16'h0000); wr(3'd2, 16'd5);
    n_rd = 0;
    @(negedge clk); launch = 1'b1;
    @(negedge clk); launch = 1'b0;
    @(negedge clk); @(negedge clk);
    prm_wr = 1'b1; prm_idx = 3'd2; prm_data = 16'd1;
    @(negedge clk);
    prm_idx = 3'd1; prm_data = 16'h0004;
    @(negedge clk);
    prm_wr = 1'b0;
    // R3 launch while busy ignored
    launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
    for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
    chk("R2 busy run reads", 32'(n_rd), 5);
    go_wait();
    chk("R2 busy writes dropped reads", 32'(n_rd), 5);
    chk("R2 busy writes dropped acc", 32'(acc_err), 0);
    chk("R2 busy writes dropped addr", 32'(first_a), 32'h7E0000);
    summary();
  end

endmodule